// File: doc/BRIEF.md
# Debug abstract command sequencer

This block sits behind a debug register interface and turns an abstract register-access command into a short machine-code stub that a halted hart executes. A 32-bit command word arrives with a one-cycle start strobe. If the command names a supported general-purpose register and access size, the block writes two instruction words into a small stub memory. The first word moves the register to or from a fixed data window using a real load or store encoding. The second word either returns to the debug loop with `ebreak` or jumps onward into a program buffer. The block then raises the go flag of the selected hart and stays busy until that hart signals completion.

The block also holds the program buffer the debugger fills. Below the writable words sits one more word that always holds `ebreak`, so any program-buffer sequence ends by itself. All three regions are read by the hart through a single word-indexed fetch port. The data window lies at `DATA_BASE`, the program buffer directly below it, and the two-word stub directly below that. If data-window or program-buffer words are marked for auto-execution, touching one of them re-runs the last command.

Top module: `abscmd_seq`

## Requirements
- R1: After reset, busy is 0, every go bit is 0, cmderr is 0, and every stub and program-buffer word reads 0 through the fetch port.
- R2: A command whose bits [31:24] are nonzero is not started. Busy stays 0, the stub is unchanged, and cmderr becomes 2 (not supported).
- R3: The register number in bits [15:0] must lie in 0x1000..0x101F and selects GPR x(regno-0x1000). Any other number gives cmderr 2 and starts nothing.
- R4: A size code in bits [22:20] of 2 gives a 32-bit access (funct3 010). A code of 3 gives a 64-bit access (funct3 011). Any other code gives cmderr 2 and starts nothing.
- R5: When bit 16 is 1, stub word 0 (fetch index 0) is a load into the GPR from offset `DATA_BASE` with base x0 (opcode 0000011). When bit 16 is 0, it is a store of the GPR to that offset with base x0 (opcode 0100011).
- R6: When bit 18 is 1, stub word 1 (fetch index 1) is `jal x0` with offset (program-buffer base − stub base − 4), which is 0x0040006F at the defaults. When bit 18 is 0, word 1 is `ebreak` (0x00100073).
- R7: In the cycle after a supported command is accepted, busy is 1 and exactly the go bit numbered by `hartsel` is 1. The stub does not change while busy.
- R8: A one-cycle `hart_done` pulse while busy clears busy and all go bits in the next cycle.
- R9: A command strobed while busy is rejected: cmderr becomes 1 (busy), and the stub, busy and go flags are unchanged.
- R10: Fetch indices 2..PB_WORDS+1 return the program-buffer words, written through `pb_wr_*`. Index PB_WORDS+2 always returns 0x00100073. `impebreak` is 1.
- R11: Program-buffer writes made while busy have no effect.
- R12: When busy is 0, an access strobe to a data word (`acc_is_pb`=0) or a program-buffer word (`acc_is_pb`=1) whose auto-execute mask bit is set re-runs the last command received. An access to an unmarked word, or any access while busy, starts nothing and sets no error.
- R13: cmderr is sticky. The first error is held until a `cmderr_clr` pulse returns it to 0. Codes: 0 none, 1 busy, 2 not supported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle command start strobe |
| cmd_word | input | 32 | Abstract command word |
| hartsel | input | HS_W | Selected hart number |
| cmderr_clr | input | 1 | Clears the sticky error code |
| pb_wr_en | input | 1 | Program-buffer word write strobe |
| pb_wr_idx | input | PB_IDX_W | Program-buffer word index |
| pb_wr_data | input | 32 | Program-buffer write data |
| acc_valid | input | 1 | Debugger touched a data or program-buffer word |
| acc_is_pb | input | 1 | 1: the access was to the program buffer; 0: to the data window |
| acc_idx | input | ACC_W | Word index of the access |
| auto_data_mask | input | DATA_WORDS | Auto-execute enables for data words |
| auto_pb_mask | input | PB_WORDS | Auto-execute enables for program-buffer words |
| hart_done | input | 1 | One-cycle completion pulse from the hart |
| fetch_idx | input | FETCH_W | Hart fetch word index (0,1 stub; then program buffer; then ebreak) |
| fetch_data | output | 32 | Fetched instruction word |
| busy | output | 1 | Command in progress |
| go | output | NHARTS | Per-hart go flags |
| cmderr | output | 3 | Sticky command error code |
| impebreak | output | 1 | Implicit trailing ebreak present |

## Verification
The assertions assume that `hart_done` is a single-cycle pulse and arrives only while busy. They also assume that `cmd_valid` and `acc_valid` are single-cycle strobes and that word indices stay inside their regions. The bench drives every strobe for exactly one cycle on the falling edge. It raises `hart_done` only after it has seen busy set, and it uses only in-range indices. It samples the fetch port and the flags on the falling edge that follows each stimulus. This covers accepted, rejected and re-run commands, and writes both while busy and while idle.

// File: rtl/abscmd_pkg.sv
package abscmd_pkg;

   typedef enum logic [2:0] {
      ERR_NONE   = 3'd0,
      ERR_BUSY   = 3'd1,
      ERR_NOTSUP = 3'd2
   } cmderr_e;

   localparam logic [31:0] EBREAK_INSN = 32'h0010_0073;

   localparam logic [6:0] OP_LOAD  = 7'b000_0011;
   localparam logic [6:0] OP_STORE = 7'b010_0011;
   localparam logic [6:0] OP_JAL   = 7'b110_1111;

   // I-type load with base x0
   function automatic logic [31:0] enc_load(input logic [4:0] rd,
                                            input logic [2:0] f3,
                                            input logic [11:0] imm);
      return {imm, 5'd0, f3, rd, OP_LOAD};
   endfunction

   // S-type store with base x0
   function automatic logic [31:0] enc_store(input logic [4:0] rs2,
                                             input logic [2:0] f3,
                                             input logic [11:0] imm);
      return {imm[11:5], rs2, 5'd0, f3, imm[4:0], OP_STORE};
   endfunction

   // J-type jump
   function automatic logic [31:0] enc_jal(input logic [4:0] rd,
                                           input logic [20:0] off);
      return {off[20], off[10:1], off[11], off[19:12], rd, OP_JAL};
   endfunction

endpackage

// File: rtl/abscmd_decode.sv
module abscmd_decode
   import abscmd_pkg::*;
#(
   parameter int DATA_BASE = 32'h380,
   parameter int PB_BASE   = 32'h374,
   parameter int STUB_BASE = 32'h36C
) (
   input  logic [31:0] cmd,
   output logic [31:0] word0,
   output logic [31:0] word1,
   output logic        notsup
);

   localparam logic [11:0] DOFF = 12'(DATA_BASE);
   localparam logic [20:0] JOFF = 21'(PB_BASE - STUB_BASE - 4);

   logic [7:0]  ctype;
   logic [2:0]  size;
   logic        postexec;
   logic        wr_gpr;
   logic [15:0] regno;
   logic        unused_fields;
   logic        type_ok, reg_ok, size_ok;
   logic [2:0]  f3;

   assign ctype         = cmd[31:24];
   assign size          = cmd[22:20];
   assign postexec      = cmd[18];
   assign wr_gpr        = cmd[16];
   assign regno         = cmd[15:0];
   assign unused_fields = ^{cmd[23], cmd[19], cmd[17]};

   always_comb begin
      type_ok = (ctype == 8'd0);
      reg_ok  = (regno[15:5] == 11'h080);
      size_ok = (size == 3'd2) || (size == 3'd3);
      f3      = (size == 3'd3) ? 3'b011 : 3'b010;
      notsup  = !(type_ok && reg_ok && size_ok);
      word0   = wr_gpr ? enc_load(regno[4:0], f3, DOFF)
                       : enc_store(regno[4:0], f3, DOFF);
      word1   = postexec ? enc_jal(5'd0, JOFF) : EBREAK_INSN;
   end

endmodule

// File: rtl/abscmd_fetchmem.sv
module abscmd_fetchmem
   import abscmd_pkg::*;
#(
   parameter int PB_WORDS = 2,
   parameter int PB_IDX_W = 1,
   parameter int FETCH_W  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               busy,
   input  logic               wr_en,
   input  logic [PB_IDX_W-1:0] wr_idx,
   input  logic [31:0]        wr_data,
   input  logic [31:0]        stub0,
   input  logic [31:0]        stub1,
   input  logic [FETCH_W-1:0] fetch_idx,
   output logic [31:0]        fetch_data
);

   localparam int TAIL_IDX = PB_WORDS + 2;

   logic [PB_WORDS-1:0][31:0] pb_q;
   logic [PB_WORDS-1:0]       wr_hit;

   for (genvar g = 0; g < PB_WORDS; g++) begin : g_hit
      assign wr_hit[g] = wr_en && !busy && (wr_idx == PB_IDX_W'(g));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pb_q <= '0;
      end else begin
         for (int i = 0; i < PB_WORDS; i++) begin
            if (wr_hit[i]) pb_q[i] <= wr_data;
         end
      end
   end

   always_comb begin
      fetch_data = '0;
      if (fetch_idx == FETCH_W'(0)) fetch_data = stub0;
      if (fetch_idx == FETCH_W'(1)) fetch_data = stub1;
      for (int i = 0; i < PB_WORDS; i++) begin
         if (fetch_idx == FETCH_W'(i + 2)) fetch_data = pb_q[i];
      end
      if (fetch_idx == FETCH_W'(TAIL_IDX)) fetch_data = EBREAK_INSN;
   end

   assert_pb_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(pb_q));

   assert_tail_ebreak_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_idx == FETCH_W'(TAIL_IDX)) |-> (fetch_data == EBREAK_INSN));

endmodule

// File: rtl/abscmd_ctrl.sv
module abscmd_ctrl
   import abscmd_pkg::*;
#(
   parameter int NHARTS = 4,
   parameter int HS_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [31:0]       cmd_word,
   input  logic              auto_hit,
   input  logic [HS_W-1:0]   hartsel,
   input  logic              hart_done,
   input  logic              cmderr_clr,
   input  logic              dec_notsup,
   output logic [31:0]       sel_cmd,
   output logic              launch,
   output logic              busy,
   output logic [NHARTS-1:0] go,
   output logic [2:0]        cmderr
);

   logic [31:0]       last_q;
   logic              busy_q;
   logic [NHARTS-1:0] go_q;
   cmderr_e           err_q, err_d;
   logic              trigger;
   logic [NHARTS-1:0] sel_hit;

   for (genvar h = 0; h < NHARTS; h++) begin : g_sel
      assign sel_hit[h] = (hartsel == HS_W'(h));
   end

   assign sel_cmd = cmd_valid ? cmd_word : last_q;
   assign trigger = (cmd_valid || auto_hit) && !busy_q;
   assign launch  = trigger && !dec_notsup;

   always_comb begin
      err_d = err_q;
      if (cmderr_clr) err_d = ERR_NONE;
      if (err_d == ERR_NONE) begin
         if (cmd_valid && busy_q)        err_d = ERR_BUSY;
         else if (trigger && dec_notsup) err_d = ERR_NOTSUP;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_q <= '0;
         busy_q <= 1'b0;
         go_q   <= '0;
         err_q  <= ERR_NONE;
      end else begin
         err_q <= err_d;
         if (cmd_valid && !busy_q) last_q <= cmd_word;
         if (launch) begin
            busy_q <= 1'b1;
            go_q   <= sel_hit;
         end else if (hart_done) begin
            busy_q <= 1'b0;
            go_q   <= '0;
         end
      end
   end

   assign busy   = busy_q;
   assign go     = go_q;
   assign cmderr = err_q;

   assert_go_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ($countones(go) == 1));

   assert_go_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (go == '0));

   assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !hart_done) |=> busy);

   assert_done_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && hart_done) |=> !busy);

   assert_reject_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_valid && (cmderr == 3'd0) && !cmderr_clr) |=> (cmderr == 3'd1));

   assert_notsup_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (trigger && dec_notsup) |=> !busy);

   assert_err_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmderr != 3'd0) && !cmderr_clr) |=> $stable(cmderr));

endmodule

// File: rtl/abscmd_seq.sv
module abscmd_seq
   import abscmd_pkg::*;
#(
   parameter int NHARTS     = 4,
   parameter int PB_WORDS   = 2,
   parameter int DATA_WORDS = 2,
   parameter int DATA_BASE  = 32'h380,
   localparam int HS_W      = (NHARTS > 1) ? $clog2(NHARTS) : 1,
   localparam int PB_IDX_W  = (PB_WORDS > 1) ? $clog2(PB_WORDS) : 1,
   localparam int DT_IDX_W  = (DATA_WORDS > 1) ? $clog2(DATA_WORDS) : 1,
   localparam int ACC_W     = (PB_IDX_W > DT_IDX_W) ? PB_IDX_W : DT_IDX_W,
   localparam int FETCH_W   = $clog2(PB_WORDS + 3)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmd_valid,
   input  logic [31:0]           cmd_word,
   input  logic [HS_W-1:0]       hartsel,
   input  logic                  cmderr_clr,
   input  logic                  pb_wr_en,
   input  logic [PB_IDX_W-1:0]   pb_wr_idx,
   input  logic [31:0]           pb_wr_data,
   input  logic                  acc_valid,
   input  logic                  acc_is_pb,
   input  logic [ACC_W-1:0]      acc_idx,
   input  logic [DATA_WORDS-1:0] auto_data_mask,
   input  logic [PB_WORDS-1:0]   auto_pb_mask,
   input  logic                  hart_done,
   input  logic [FETCH_W-1:0]    fetch_idx,
   output logic [31:0]           fetch_data,
   output logic                  busy,
   output logic [NHARTS-1:0]     go,
   output logic [2:0]            cmderr,
   output logic                  impebreak
);

   localparam int PB_BASE   = DATA_BASE - 4 * (PB_WORDS + 1);
   localparam int STUB_BASE = PB_BASE - 8;

   if (NHARTS < 2 || PB_WORDS < 1 || DATA_WORDS < 2) begin : g_bad_size
      $error("abscmd_seq: NHARTS>=2, PB_WORDS>=1, DATA_WORDS>=2 required");
   end
   if (DATA_BASE + 4 * DATA_WORDS > 2048 || STUB_BASE < 0 || (DATA_BASE % 4) != 0) begin : g_bad_map
      $error("abscmd_seq: regions must be word aligned inside the x0-relative 12-bit offset range");
   end

   logic [31:0] sel_cmd, dec_w0, dec_w1;
   logic        dec_notsup, launch, auto_hit;
   logic [31:0] stub0_q, stub1_q;
   logic [DATA_WORDS-1:0] data_hit;
   logic [PB_WORDS-1:0]   pbuf_hit;

   for (genvar d = 0; d < DATA_WORDS; d++) begin : g_dhit
      assign data_hit[d] = !acc_is_pb && (acc_idx == ACC_W'(d)) && auto_data_mask[d];
   end
   for (genvar p = 0; p < PB_WORDS; p++) begin : g_phit
      assign pbuf_hit[p] = acc_is_pb && (acc_idx == ACC_W'(p)) && auto_pb_mask[p];
   end
   assign auto_hit = acc_valid && ((|data_hit) || (|pbuf_hit));

   abscmd_ctrl #(.NHARTS(NHARTS), .HS_W(HS_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
      .auto_hit(auto_hit), .hartsel(hartsel), .hart_done(hart_done),
      .cmderr_clr(cmderr_clr), .dec_notsup(dec_notsup), .sel_cmd(sel_cmd),
      .launch(launch), .busy(busy), .go(go), .cmderr(cmderr)
   );

   abscmd_decode #(.DATA_BASE(DATA_BASE), .PB_BASE(PB_BASE), .STUB_BASE(STUB_BASE)) u_dec (
      .cmd(sel_cmd), .word0(dec_w0), .word1(dec_w1), .notsup(dec_notsup)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stub0_q <= '0;
         stub1_q <= '0;
      end else if (launch) begin
         stub0_q <= dec_w0;
         stub1_q <= dec_w1;
      end
   end

   abscmd_fetchmem #(.PB_WORDS(PB_WORDS), .PB_IDX_W(PB_IDX_W), .FETCH_W(FETCH_W)) u_mem (
      .clk(clk), .rst_n(rst_n), .busy(busy), .wr_en(pb_wr_en), .wr_idx(pb_wr_idx),
      .wr_data(pb_wr_data), .stub0(stub0_q), .stub1(stub1_q),
      .fetch_idx(fetch_idx), .fetch_data(fetch_data)
   );

   assign impebreak = 1'b1;

   assert_stub_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(stub0_q) && $stable(stub1_q)));

   assert_idle_no_go_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && acc_valid && !auto_hit && !cmd_valid) |=> !busy);

endmodule

// File: tb/abscmd_seq_tb.sv
module abscmd_seq_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [31:0] cmd_word = '0;
   logic [1:0]  hartsel = '0;
   logic        cmderr_clr = 1'b0;
   logic        pb_wr_en = 1'b0;
   logic [0:0]  pb_wr_idx = '0;
   logic [31:0] pb_wr_data = '0;
   logic        acc_valid = 1'b0;
   logic        acc_is_pb = 1'b0;
   logic [0:0]  acc_idx = '0;
   logic [1:0]  auto_data_mask = '0;
   logic [1:0]  auto_pb_mask = '0;
   logic        hart_done = 1'b0;
   logic [2:0]  fetch_idx = '0;
   logic [31:0] fetch_data;
   logic        busy;
   logic [3:0]  go;
   logic [2:0]  cmderr;
   logic        impebreak;

   int errors = 0;
   int checks = 0;

   localparam logic [31:0] EBK = 32'h0010_0073;
   localparam logic [31:0] JMP = 32'h0040_006F;

   always #5 clk = ~clk;

   abscmd_seq u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
      .hartsel(hartsel), .cmderr_clr(cmderr_clr), .pb_wr_en(pb_wr_en),
      .pb_wr_idx(pb_wr_idx), .pb_wr_data(pb_wr_data), .acc_valid(acc_valid),
      .acc_is_pb(acc_is_pb), .acc_idx(acc_idx), .auto_data_mask(auto_data_mask),
      .auto_pb_mask(auto_pb_mask), .hart_done(hart_done), .fetch_idx(fetch_idx),
      .fetch_data(fetch_data), .busy(busy), .go(go), .cmderr(cmderr),
      .impebreak(impebreak)
   );

   // expected encodings: data window at 0x380, base x0
   function automatic logic [31:0] x_load(input int rd, input bit dbl);
      return (32'h380 << 20) | ((dbl ? 32'd3 : 32'd2) << 12) | (32'(rd) << 7) | 32'h03;
   endfunction
   function automatic logic [31:0] x_store(input int rs, input bit dbl);
      return (32'h1C << 25) | (32'(rs) << 20) | ((dbl ? 32'd3 : 32'd2) << 12) | 32'h23;
   endfunction

   // scoreboard queues
   int          q_idx[$];
   logic [31:0] q_data[$];
   logic [7:0]  q_flags[$];
   string       q_req[$];

   task automatic expect_snap(input int idx, input logic [31:0] d, input logic b,
                              input logic [3:0] g, input logic [2:0] e, input string r);
      q_idx.push_back(idx);
      q_data.push_back(d);
      q_flags.push_back({b, g, e});
      q_req.push_back(r);
   endtask

   task automatic drain();
      wait (q_idx.size() == 0);
      #1;
   endtask

   initial begin : monitor
      forever begin
         int          idx;
         logic [31:0] d;
         logic [7:0]  f;
         string       r;
         wait (q_idx.size() != 0);
         idx = q_idx[0];
         d   = q_data[0];
         f   = q_flags[0];
         r   = q_req[0];
         fetch_idx = 3'(idx);
         #1;
         checks++;
         if (fetch_data !== d || {busy, go, cmderr} !== f) begin
            errors++;
            $display("FAIL %s: idx=%0d data=%h flags=%b expected data=%h flags=%b",
                     r, idx, fetch_data, {busy, go, cmderr}, d, f);
         end
         void'(q_idx.pop_front());
         void'(q_data.pop_front());
         void'(q_flags.pop_front());
         void'(q_req.pop_front());
      end
   end

   task automatic send_cmd(input logic [31:0] w, input logic [1:0] hs);
      @(negedge clk);
      cmd_word = w; hartsel = hs; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic finish_cmd();
      @(negedge clk); hart_done = 1'b1;
      @(negedge clk); hart_done = 1'b0;
   endtask

   task automatic clear_err();
      @(negedge clk); cmderr_clr = 1'b1;
      @(negedge clk); cmderr_clr = 1'b0;
   endtask

   task automatic pb_write(input logic [0:0] i, input logic [31:0] v);
      @(negedge clk); pb_wr_en = 1'b1; pb_wr_idx = i; pb_wr_data = v;
      @(negedge clk); pb_wr_en = 1'b0;
   endtask

   task automatic touch(input logic is_pb, input logic [0:0] i);
      @(negedge clk); acc_valid = 1'b1; acc_is_pb = is_pb; acc_idx = i;
      @(negedge clk); acc_valid = 1'b0;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin : watchdog
      #2000000;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin : driver
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state, R10 tail word
      expect_snap(0, 32'h0, 1'b0, 4'b0000, 3'd0, "R1");
      expect_snap(1, 32'h0, 1'b0, 4'b0000, 3'd0, "R1");
      expect_snap(2, 32'h0, 1'b0, 4'b0000, 3'd0, "R1");
      expect_snap(3, 32'h0, 1'b0, 4'b0000, 3'd0, "R1");
      expect_snap(4, EBK,   1'b0, 4'b0000, 3'd0, "R10");
      drain();
      checks++;
      if (impebreak !== 1'b1) begin
         errors++;
         $display("FAIL R10: impebreak=%b expected=1", impebreak);
      end

      // R10 program buffer written while idle
      pb_write(1'b0, 32'h1111_1111);
      pb_write(1'b1, 32'h2222_2222);
      expect_snap(2, 32'h1111_1111, 1'b0, 4'b0000, 3'd0, "R10");
      expect_snap(3, 32'h2222_2222, 1'b0, 4'b0000, 3'd0, "R10");
      expect_snap(4, EBK,           1'b0, 4'b0000, 3'd0, "R10");
      drain();

      // R4 R5 R6 R7: write x5, 32-bit, no postexec, hart 2
      send_cmd(32'h0021_1005, 2'd2);
      expect_snap(0, x_load(5, 1'b0), 1'b1, 4'b0100, 3'd0, "R5");
      expect_snap(1, EBK,             1'b1, 4'b0100, 3'd0, "R6");
      drain();

      // R11 write while busy ignored
      pb_write(1'b0, 32'hDEAD_BEEF);
      expect_snap(2, 32'h1111_1111, 1'b1, 4'b0100, 3'd0, "R11");
      drain();

      // R9 command while busy rejected
      send_cmd(32'h0034_101F, 2'd1);
      expect_snap(0, x_load(5, 1'b0), 1'b1, 4'b0100, 3'd1, "R9");
      expect_snap(1, EBK,             1'b1, 4'b0100, 3'd1, "R9");
      drain();

      // R8 done, R13 sticky
      finish_cmd();
      expect_snap(0, x_load(5, 1'b0), 1'b0, 4'b0000, 3'd1, "R8");
      drain();
      clear_err();
      expect_snap(0, x_load(5, 1'b0), 1'b0, 4'b0000, 3'd0, "R13");
      drain();

      // R4 R5 R6: read x31, 64-bit, postexec, hart 1
      send_cmd(32'h0034_101F, 2'd1);
      expect_snap(0, x_store(31, 1'b1), 1'b1, 4'b0010, 3'd0, "R5");
      expect_snap(1, JMP,               1'b1, 4'b0010, 3'd0, "R6");
      drain();
      finish_cmd();

      // R2 nonzero command type
      send_cmd(32'h0122_1005, 2'd0);
      expect_snap(0, x_store(31, 1'b1), 1'b0, 4'b0000, 3'd2, "R2");
      expect_snap(1, JMP,               1'b0, 4'b0000, 3'd2, "R2");
      drain();
      clear_err();

      // R3 register range
      send_cmd(32'h0022_1020, 2'd0);
      expect_snap(0, x_store(31, 1'b1), 1'b0, 4'b0000, 3'd2, "R3");
      drain();
      clear_err();
      send_cmd(32'h0022_0FFF, 2'd0);
      expect_snap(0, x_store(31, 1'b1), 1'b0, 4'b0000, 3'd2, "R3");
      drain();
      clear_err();
      send_cmd(32'h0020_1000, 2'd0);
      expect_snap(0, x_store(0, 1'b0), 1'b1, 4'b0001, 3'd0, "R3");
      expect_snap(1, EBK,              1'b1, 4'b0001, 3'd0, "R3");
      drain();
      finish_cmd();

      // R4 unsupported size
      send_cmd(32'h0041_1005, 2'd0);
      expect_snap(0, x_store(0, 1'b0), 1'b0, 4'b0000, 3'd2, "R4");
      drain();
      clear_err();

      // R12 auto-execute
      send_cmd(32'h0031_1007, 2'd3);
      expect_snap(0, x_load(7, 1'b1), 1'b1, 4'b1000, 3'd0, "R4");
      drain();
      finish_cmd();
      pb_write(1'b0, 32'h3333_3333);
      auto_data_mask = 2'b10;
      auto_pb_mask   = 2'b01;
      touch(1'b0, 1'b1);
      expect_snap(0, x_load(7, 1'b1), 1'b1, 4'b1000, 3'd0, "R12");
      expect_snap(2, 32'h3333_3333,   1'b1, 4'b1000, 3'd0, "R10");
      drain();
      touch(1'b0, 1'b1);
      expect_snap(0, x_load(7, 1'b1), 1'b1, 4'b1000, 3'd0, "R12");
      drain();
      finish_cmd();
      touch(1'b0, 1'b0);
      expect_snap(0, x_load(7, 1'b1), 1'b0, 4'b0000, 3'd0, "R12");
      drain();
      @(negedge clk); hartsel = 2'd1;
      touch(1'b1, 1'b0);
      expect_snap(0, x_load(7, 1'b1), 1'b1, 4'b0010, 3'd0, "R12");
      drain();
      finish_cmd();
      expect_snap(1, EBK, 1'b0, 4'b0000, 3'd0, "R8");
      drain();

      summary();
      $finish;
   end

endmodule